// File: doc/BRIEF.md
# SD Command Issue and Response Unit

This block sends one command to an SD card over the single-wire command line and collects the card's reply. Software (or an upstream register file) presents a packed 32-bit command word and a 32-bit argument and pulses a write strobe. The unit builds the 48-bit command token, computes its CRC7, and shifts it out one bit per card-clock tick. It then waits for the card's response and captures it. The response may be absent, 48 bits long, 136 bits long, or 48 bits followed by a busy period on the data lines.

When the response is in, the unit checks its end bit. If those checks are enabled in the command word, it also checks the index echo and the CRC. It fills four 32-bit response registers and raises a one-cycle event on a 20-bit event vector, with the bit positions chosen to match a conventional interrupt status word. Two status flags guard issue: one for the command line and one for the data lines. Two strobes let software reset the command path and the data-side flag separately.

Card-clock pacing comes from an external one-cycle `bit_tick` strobe. Data-line transfers are handled elsewhere. Only the "data lines active / busy" indication, `dat_busy`, enters this block.

Top module: `sdcmd_unit`

## Requirements
- R1: After acceptance, the token is driven on `cmd_out` with `cmd_oe` high, one bit per tick, most significant bit first, as 48 bits: start 0, transmission 1, index[5:0], argument[31:0], CRC7 (x^7+x^3+1, zero seed, over the first 40 bits), end 1. On the tick after the end bit, `cmd_oe` drops and `cmd_out` idles high.
- R2: The command word is decoded as follows: index in bits 29:24, data flag in bit 21, index-check enable in bit 20, CRC-check enable in bit 19, and response kind in bits 17:16. The kind codes are 0 none, 1 136-bit, 2 48-bit and 3 48-bit with busy. Bits 5 (multi-block) and 4 (direction), and all other bits, have no effect on this unit.
- R3: `cmd_inhibit` and `dat_inhibit` are 0 after reset. `cmd_inhibit` rises on acceptance and stays 1 until the command completes or fails.
- R4: A write strobe is ignored while `cmd_inhibit` is 1. A write strobe for a command that needs the data lines is ignored while `dat_inhibit` is 1, but a command without data and without busy is still accepted then.
- R5: A command with no response completes with event bit 0 right after its end bit.
- R6: For 48-bit kinds, `resp0` holds the 32 card-status bits, which are response bits 39:8.
- R7: For the 136-bit kind, response bits 127:8 are stored without the CRC byte: `resp0`=bits 39:8, `resp1`=71:40, `resp2`=103:72, `resp3`={8'h00, bits 127:104}.
- R8: If no start bit (0) is sampled within `RESP_TO` (64) ticks after the release tick, only event bit 16 (timeout) is raised. A start bit on the 64th tick is still accepted.
- R9: With CRC check enabled, a CRC7 mismatch raises event bit 17 and not bit 0. With CRC check disabled, a corrupted CRC is not reported. The check covers response bits 47:8 for 48-bit replies and bits 127:8 for 136-bit replies.
- R10: A 0 in the final response bit raises event bit 18 (end-bit error) and not bit 0.
- R11: With index check enabled, a 48-bit response whose bits 45:40 differ from the command index raises event bit 19. With index check disabled, or for 136-bit replies, the mismatch is not reported.
- R12: For the busy kind, `dat_inhibit` stays 1 while `dat_busy` is 1 after the response. It clears once `dat_busy` is 0, and event bit 1 (transfer complete) is raised if the response had no error.
- R13: A `rst_cmd` pulse aborts the command, clears `cmd_inhibit` and releases the line, and leaves `dat_inhibit` unchanged. A `rst_dat` pulse clears `dat_inhibit`.
- R14: Acceptance of a command with the data flag set or with the busy kind sets `dat_inhibit`. `dat_inhibit` clears after completion once `dat_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for command word and argument |
| cmd_word | input | 32 | Packed command/transfer-mode word |
| cmd_arg | input | 32 | Command argument |
| rst_cmd | input | 1 | Command-path reset strobe |
| rst_dat | input | 1 | Data-side flag reset strobe |
| bit_tick | input | 1 | One-cycle strobe per card clock period |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Command line sampled value |
| dat_busy | input | 1 | Data lines busy or transfer active |
| cmd_inhibit | output | 1 | Command line in use |
| dat_inhibit | output | 1 | Data lines reserved |
| evt | output | 20 | One-cycle event pulses (0 done, 1 transfer done, 16 timeout, 17 CRC, 18 end bit, 19 index) |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |

## Verification
The bench targets the timeout boundary with a start bit on exactly the 64th sampled tick and with 64 idle ticks. A counter that is off by one would either report a timeout for a valid reply or accept a late one. Single-bit corruptions of the CRC, the end bit and the echoed index are each injected with their check enabled and disabled. This catches a design that ignores the enable bits, that folds the wrong bit range into the CRC, or that reports an error together with completion. The 136-bit reply checks the byte-shifted packing, where a wrong slice shows up as every response word off by 8 bits. A busy command is held with the data lines busy while a data command is offered and a plain command is run. A design that released the data flag early, or that locked out all commands, would fail there.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int TOK_BITS   = 48;
    localparam int SHORT_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int CAP_BITS   = 128;
    localparam int CRC_W      = 7;
    localparam int EVT_W      = 20;

    localparam int EV_DONE = 0;
    localparam int EV_XFER = 1;
    localparam int EV_TMO  = 16;
    localparam int EV_CRC  = 17;
    localparam int EV_END  = 18;
    localparam int EV_IDX  = 19;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_LONG = 2'd1,
        RSP_SHRT = 2'd2,
        RSP_BUSY = 2'd3
    } rsp_e;

    typedef struct packed {
        logic [5:0] idx;
        rsp_e       rsp;
        logic       dat;
        logic       idx_chk;
        logic       crc_chk;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [31:0] w);
        cmd_t c;
        c.idx     = w[29:24];
        c.rsp     = rsp_e'(w[17:16]);
        c.dat     = w[21];
        c.idx_chk = w[20];
        c.crc_chk = w[19];
        return c;
    endfunction

    function automatic logic uses_dat(input cmd_t c);
        return c.dat || (c.rsp == RSP_BUSY);
    endfunction

    // serial CRC7 update, generator x^7 + x^3 + 1
    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:3], c[2] ^ fb, c[1:0], fb};
    endfunction

    function automatic logic [CRC_W-1:0] crc7_msg(input logic [39:0] m);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = 39; i >= 0; i--) c = crc7_step(c, m[i]);
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
    import sdcmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        abort,
    input  logic        start,
    input  logic        tick,
    input  logic [5:0]  idx,
    input  logic [31:0] arg,
    output logic        line,
    output logic        oe,
    output logic        done
);
    localparam int CW = $clog2(TOK_BITS + 1);

    logic [TOK_BITS-1:0] tok;
    logic [CW-1:0]       cnt;
    logic                run;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            tok  <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            line <= 1'b1;
            oe   <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                tok <= {2'b01, idx, arg, crc7_msg({2'b01, idx, arg}), 1'b1};
                cnt <= '0;
                run <= 1'b1;
            end else if (run && tick) begin
                if (cnt == CW'(TOK_BITS)) begin
                    run  <= 1'b0;
                    oe   <= 1'b0;
                    line <= 1'b1;
                    done <= 1'b1;
                end else begin
                    line <= tok[TOK_BITS-1];
                    tok  <= {tok[TOK_BITS-2:0], 1'b1};
                    oe   <= 1'b1;
                    cnt  <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
    import sdcmd_pkg::*;
#(
    parameter int TO_TICKS = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                abort,
    input  logic                arm,
    input  logic                long_rsp,
    input  logic                tick,
    input  logic                din,
    output logic                done,
    output logic                tmo,
    output logic [CAP_BITS-1:0] sh,
    output logic [CRC_W-1:0]    crc
);
    localparam int WW = (TO_TICKS > 2) ? $clog2(TO_TICKS) : 1;
    localparam int RW = $clog2(LONG_BITS);

    typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_BITS} rx_st_e;

    rx_st_e        st;
    logic [WW-1:0] wcnt;
    logic [RW-1:0] rcnt;
    logic          long_q;
    logic [RW-1:0] last;

    function automatic logic in_crc(input logic [RW-1:0] r, input logic lg);
        if (lg) return (r >= RW'(8)) && (r < RW'(CAP_BITS));
        return r < RW'(SHORT_BITS - 8);
    endfunction

    assign last = long_q ? RW'(LONG_BITS - 1) : RW'(SHORT_BITS - 1);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st     <= RX_IDLE;
            wcnt   <= '0;
            rcnt   <= '0;
            long_q <= 1'b0;
            sh     <= '0;
            crc    <= '0;
            done   <= 1'b0;
            tmo    <= 1'b0;
        end else begin
            done <= 1'b0;
            tmo  <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (arm) begin
                        st     <= RX_WAIT;
                        wcnt   <= '0;
                        crc    <= '0;
                        long_q <= long_rsp;
                    end
                end
                RX_WAIT: begin
                    if (tick) begin
                        if (!din) begin
                            sh   <= {sh[CAP_BITS-2:0], 1'b0};
                            if (in_crc('0, long_q)) crc <= crc7_step(crc, 1'b0);
                            rcnt <= RW'(1);
                            st   <= RX_BITS;
                        end else if (wcnt == WW'(TO_TICKS - 1)) begin
                            tmo <= 1'b1;
                            st  <= RX_IDLE;
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end
                end
                RX_BITS: begin
                    if (tick) begin
                        sh <= {sh[CAP_BITS-2:0], din};
                        if (in_crc(rcnt, long_q)) crc <= crc7_step(crc, din);
                        if (rcnt == last) begin
                            done <= 1'b1;
                            st   <= RX_IDLE;
                        end else begin
                            rcnt <= rcnt + 1'b1;
                        end
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdcmd_unit.sv
module sdcmd_unit
    import sdcmd_pkg::*;
#(
    parameter int RESP_TO = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [31:0]      cmd_word,
    input  logic [31:0]      cmd_arg,
    input  logic             rst_cmd,
    input  logic             rst_dat,
    input  logic             bit_tick,
    output logic             cmd_out,
    output logic             cmd_oe,
    input  logic             cmd_in,
    input  logic             dat_busy,
    output logic             cmd_inhibit,
    output logic             dat_inhibit,
    output logic [EVT_W-1:0] evt,
    output logic [31:0]      resp0,
    output logic [31:0]      resp1,
    output logic [31:0]      resp2,
    output logic [31:0]      resp3
);
    cmd_t                dec;
    cmd_t                cur;
    logic                accept;
    logic                tx_done;
    logic                rx_done;
    logic                rx_tmo;
    logic                rx_arm;
    logic [CAP_BITS-1:0] sh;
    logic [CRC_W-1:0]    rx_crc;
    logic                finish;
    logic                e_end;
    logic                e_crc;
    logic                e_idx;
    logic                ok;
    logic                dat_pend;
    logic                pend_xfer;
    logic                unused_bits;

    assign dec         = decode_cmd(cmd_word);
    assign unused_bits = ^{cmd_word[31:30], cmd_word[23:22], cmd_word[18], cmd_word[15:0]};
    assign accept      = cmd_wr && !rst_cmd && !cmd_inhibit && !(uses_dat(dec) && dat_inhibit);
    assign rx_arm      = tx_done && (cur.rsp != RSP_NONE);
    assign finish      = (tx_done && (cur.rsp == RSP_NONE)) || rx_done || rx_tmo;

    assign e_end = rx_done && !sh[0];
    assign e_crc = rx_done && cur.crc_chk && (rx_crc != sh[7:1]);
    assign e_idx = rx_done && cur.idx_chk && (cur.rsp != RSP_LONG) && (sh[45:40] != cur.idx);
    assign ok    = !rx_tmo && !e_end && !e_crc && !e_idx;

    sdcmd_tx u_tx (
        .clk  (clk),
        .rst  (rst),
        .abort(rst_cmd),
        .start(accept),
        .tick (bit_tick),
        .idx  (dec.idx),
        .arg  (cmd_arg),
        .line (cmd_out),
        .oe   (cmd_oe),
        .done (tx_done)
    );

    sdcmd_rx #(.TO_TICKS(RESP_TO)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .abort   (rst_cmd),
        .arm     (rx_arm),
        .long_rsp(cur.rsp == RSP_LONG),
        .tick    (bit_tick),
        .din     (cmd_in),
        .done    (rx_done),
        .tmo     (rx_tmo),
        .sh      (sh),
        .crc     (rx_crc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur         <= '0;
            cmd_inhibit <= 1'b0;
            dat_inhibit <= 1'b0;
            dat_pend    <= 1'b0;
            pend_xfer   <= 1'b0;
            evt         <= '0;
            resp0       <= '0;
            resp1       <= '0;
            resp2       <= '0;
            resp3       <= '0;
        end else begin
            evt <= '0;
            if (rst_cmd) begin
                cmd_inhibit <= 1'b0;
            end else if (accept) begin
                cmd_inhibit <= 1'b1;
                cur         <= dec;
                if (uses_dat(dec)) dat_inhibit <= 1'b1;
            end else if (finish) begin
                cmd_inhibit    <= 1'b0;
                evt[EV_DONE]   <= ok;
                evt[EV_TMO]    <= rx_tmo;
                evt[EV_CRC]    <= e_crc;
                evt[EV_END]    <= e_end;
                evt[EV_IDX]    <= e_idx;
                if (uses_dat(cur)) begin
                    dat_pend  <= 1'b1;
                    pend_xfer <= (cur.rsp == RSP_BUSY) && ok;
                end
                if (rx_done) begin
                    resp0 <= sh[39:8];
                    if (cur.rsp == RSP_LONG) begin
                        resp1 <= sh[71:40];
                        resp2 <= sh[103:72];
                        resp3 <= {8'h00, sh[127:104]};
                    end
                end
            end
            if (rst_dat) begin
                dat_inhibit <= 1'b0;
                dat_pend    <= 1'b0;
                pend_xfer   <= 1'b0;
            end else if (dat_pend && !dat_busy) begin
                dat_inhibit   <= 1'b0;
                dat_pend      <= 1'b0;
                pend_xfer     <= 1'b0;
                evt[EV_XFER]  <= pend_xfer;
            end
        end
    end
endmodule

// File: rtl/sdcmd_unit_chk.sv
module sdcmd_unit_chk
    import sdcmd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rst_cmd,
    input logic             rst_dat,
    input logic             cmd_oe,
    input logic             cmd_inhibit,
    input logic             dat_inhibit,
    input logic             dat_busy,
    input logic [EVT_W-1:0] evt
);
    logic any_err;
    assign any_err = evt[EV_TMO] || evt[EV_CRC] || evt[EV_END] || evt[EV_IDX];

    p_oe_in_cmd_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_oe |-> cmd_inhibit);

    p_inhibit_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_inhibit) |-> ($past(rst_cmd) || $past(rst) || evt[EV_DONE] || any_err));

    p_done_no_err_r5: assert property (@(posedge clk) disable iff (rst)
        evt[EV_DONE] |-> !any_err);

    p_tmo_alone_r8: assert property (@(posedge clk) disable iff (rst)
        evt[EV_TMO] |-> !(evt[EV_CRC] || evt[EV_END] || evt[EV_IDX]));

    p_dat_release_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(dat_inhibit) |-> (!$past(dat_busy) || $past(rst_dat) || $past(rst)));

    p_xfer_clear_r12: assert property (@(posedge clk) disable iff (rst)
        evt[EV_XFER] |-> !dat_inhibit);

    p_cmd_reset_r13: assert property (@(posedge clk) disable iff (rst)
        rst_cmd |=> (!cmd_inhibit && !cmd_oe));
endmodule

bind sdcmd_unit sdcmd_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rst_cmd    (rst_cmd),
    .rst_dat    (rst_dat),
    .cmd_oe     (cmd_oe),
    .cmd_inhibit(cmd_inhibit),
    .dat_inhibit(dat_inhibit),
    .dat_busy   (dat_busy),
    .evt        (evt)
);

// File: tb/sdcmd_unit_test.sv
module sdcmd_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [31:0] cmd_arg = '0;
    logic        rst_cmd = 1'b0;
    logic        rst_dat = 1'b0;
    logic        bit_tick = 1'b0;
    logic        cmd_out;
    logic        cmd_oe;
    logic        cmd_in = 1'b1;
    logic        dat_busy = 1'b0;
    logic        cmd_inhibit;
    logic        dat_inhibit;
    logic [19:0] evt;
    logic [31:0] resp0, resp1, resp2, resp3;

    logic [19:0] seen = '0;
    logic        seen_clr = 1'b0;
    int          total = 0;
    int          fails = 0;

    always #2.5 clk = ~clk;

    sdcmd_unit uut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word), .cmd_arg(cmd_arg),
        .rst_cmd(rst_cmd), .rst_dat(rst_dat), .bit_tick(bit_tick),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in), .dat_busy(dat_busy),
        .cmd_inhibit(cmd_inhibit), .dat_inhibit(dat_inhibit), .evt(evt),
        .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3)
    );

    always @(posedge clk) begin
        if (seen_clr) seen <= '0;
        else seen <= seen | evt;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // CRC7 by long division, message MSB first
    function automatic logic [6:0] ref_crc(input logic [119:0] v, input int n);
        logic [7:0] r;
        r = '0;
        for (int i = n - 1; i >= 0; i--) begin
            r = {r[6:0], v[i]};
            if (r[7]) r = r ^ 8'b1000_1001;
        end
        for (int k = 0; k < 7; k++) begin
            r = {r[6:0], 1'b0};
            if (r[7]) r = r ^ 8'b1000_1001;
        end
        return r[6:0];
    endfunction

    task automatic tk(input logic b);
        @(negedge clk);
        cmd_in   = b;
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    // mode: 0 good, 1 crc flip, 2 end bit low, 3 index mismatch, 4 no reply
    task automatic run_txn(input logic [31:0] w, input logic [31:0] a, input int mode,
                           input int gap, input bit hold, input bit poke);
        logic [5:0]   ix;
        logic [1:0]   rk;
        logic         needs;
        logic [47:0]  tok;
        logic [39:0]  m40;
        logic [119:0] body;
        logic [135:0] rv;
        logic [31:0]  status;
        logic [19:0]  exp;
        int           len;
        int           errs;
        string        tag;
        ix    = w[29:24];
        rk    = w[17:16];
        needs = w[21] || (rk == 2'd3);
        tok   = {2'b01, ix, a, ref_crc({80'h0, 2'b01, ix, a}, 40), 1'b1};
        if (rk == 2'd3) dat_busy = 1'b1;
        @(negedge clk);
        cmd_word = w; cmd_arg = a; cmd_wr = 1'b1; seen_clr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0; seen_clr = 1'b0;
        chk("R3 inhibit on accept", {31'd0, cmd_inhibit}, 32'd1);
        if (needs) chk("R14 data flag", {31'd0, dat_inhibit}, 32'd1);
        errs = 0;
        for (int i = 0; i < 48; i++) begin
            if (poke && i == 10) begin
                @(negedge clk);
                cmd_word = ~w; cmd_arg = ~a; cmd_wr = 1'b1;
                @(negedge clk);
                cmd_wr = 1'b0;
            end
            tk(1'b1);
            if (cmd_out !== tok[47 - i] || cmd_oe !== 1'b1) errs++;
        end
        tk(1'b1);
        if (cmd_oe !== 1'b0 || cmd_out !== 1'b1) errs++;
        chk("R1 token bits", errs, 0);
        if (poke) chk("R4 write while busy ignored", errs, 0);
        exp = 20'h1;
        if (rk == 2'd0) begin
            @(negedge clk); @(negedge clk);
            chk("R5 no-response done", {12'd0, seen}, 32'h1);
        end else begin
            status = $urandom;
            body   = {$urandom, $urandom, $urandom, $urandom};
            rv     = '0;
            if (rk == 2'd1) begin
                len = 136;
                rv  = {8'b0011_1111, body, ref_crc(body, 120), 1'b1};
            end else begin
                len = 48;
                m40 = {2'b00, (mode == 3) ? (ix ^ 6'h01) : ix, status};
                rv[47:0] = {m40, ref_crc({80'h0, m40}, 40), 1'b1};
            end
            tag = "R2 good";
            if (mode == 1) begin
                rv[1] = ~rv[1];
                exp   = w[19] ? 20'h20000 : 20'h1;
                tag   = "R9 crc";
            end else if (mode == 2) begin
                rv[0] = 1'b0;
                exp   = 20'h40000;
                tag   = "R10 end bit";
            end else if (mode == 3 && rk != 2'd1) begin
                exp = w[20] ? 20'h80000 : 20'h1;
                tag = "R11 index";
            end else if (mode == 4) begin
                exp = 20'h10000;
                tag = "R8 timeout";
            end
            if (mode == 4) begin
                for (int i = 0; i < 64; i++) tk(1'b1);
            end else begin
                for (int i = 0; i < gap; i++) tk(1'b1);
                for (int i = 0; i < len; i++) tk(rv[len - 1 - i]);
            end
            cmd_in = 1'b1;
            @(negedge clk); @(negedge clk);
            chk(tag, {12'd0, seen & 20'hF_FFFD}, {12'd0, exp});
            chk("R3 inhibit released", {31'd0, cmd_inhibit}, 32'd0);
            if (exp == 20'h1 && mode != 4) begin
                if (rk == 2'd1) begin
                    chk("R7 resp0", resp0, body[31:0]);
                    chk("R7 resp1", resp1, body[63:32]);
                    chk("R7 resp2", resp2, body[95:64]);
                    chk("R7 resp3", resp3, {8'h00, body[119:96]});
                end else begin
                    chk("R6 status word", resp0, status);
                end
            end
        end
        if (rk == 2'd3 && !hold) begin
            chk("R12 held while busy", {31'd0, dat_inhibit}, 32'd1);
            chk("R12 no early xfer", {31'd0, seen[1]}, 32'd0);
            @(negedge clk);
            dat_busy = 1'b0;
            @(negedge clk); @(negedge clk); @(negedge clk);
            chk("R12 released", {31'd0, dat_inhibit}, 32'd0);
            chk("R12 xfer event", {31'd0, seen[1]}, {31'd0, exp == 20'h1});
        end else if (needs && !hold) begin
            @(negedge clk); @(negedge clk);
            chk("R14 data flag cleared", {31'd0, dat_inhibit}, 32'd0);
        end
    endtask

    function automatic logic [31:0] mkw(input logic [5:0] ix, input logic [1:0] rk,
                                        input logic d, input logic ic, input logic cc);
        return {2'b00, ix, 2'b00, d, ic, cc, 1'b0, rk, 16'h0030};
    endfunction

    initial begin
        repeat (180000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17_C0DE));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 reset cmd inhibit", {31'd0, cmd_inhibit}, 32'd0);
        chk("R3 reset dat inhibit", {31'd0, dat_inhibit}, 32'd0);
        chk("R1 idle line", {30'd0, cmd_oe, cmd_out}, 32'd1);

        run_txn(mkw(6'd0, 2'd0, 0, 0, 0), 32'h0, 0, 0, 0, 0);
        run_txn(mkw(6'd13, 2'd2, 0, 1, 1), 32'h1234_5678, 0, 0, 0, 0);
        run_txn(mkw(6'd8, 2'd2, 0, 1, 1), 32'h0000_01AA, 0, 63, 0, 0);
        run_txn(mkw(6'd8, 2'd2, 0, 1, 1), 32'h0000_01AA, 4, 0, 0, 0);
        run_txn(mkw(6'd2, 2'd1, 0, 0, 1), 32'h0, 0, 3, 0, 0);
        run_txn(mkw(6'd9, 2'd1, 0, 0, 0), 32'hFFFF_0000, 1, 2, 0, 0);
        run_txn(mkw(6'd17, 2'd2, 1, 1, 1), 32'h0000_0200, 1, 1, 0, 0);
        run_txn(mkw(6'd55, 2'd2, 0, 1, 0), 32'hA5A5_0000, 1, 1, 0, 0);
        run_txn(mkw(6'd3, 2'd2, 0, 1, 1), 32'h0, 2, 4, 0, 0);
        run_txn(mkw(6'd16, 2'd2, 0, 1, 1), 32'h200, 3, 4, 0, 0);
        run_txn(mkw(6'd16, 2'd2, 0, 0, 1), 32'h200, 3, 4, 0, 0);
        run_txn(mkw(6'd7, 2'd3, 0, 1, 1), 32'h1, 0, 5, 0, 1);

        // busy command held; data command must be refused, plain command accepted
        run_txn(mkw(6'd12, 2'd3, 0, 1, 1), 32'h0, 0, 5, 1, 0);
        chk("R12 held while busy", {31'd0, dat_inhibit}, 32'd1);
        @(negedge clk);
        cmd_word = mkw(6'd18, 2'd2, 1, 1, 1); cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        @(negedge clk);
        chk("R4 data command refused", {31'd0, cmd_inhibit}, 32'd0);
        tk(1'b1);
        chk("R4 line untouched", {31'd0, cmd_oe}, 32'd0);
        run_txn(mkw(6'd0, 2'd0, 0, 0, 0), 32'h0, 0, 0, 0, 0);
        @(negedge clk);
        dat_busy = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 released after hold", {31'd0, dat_inhibit}, 32'd0);
        chk("R12 xfer after hold", {31'd0, seen[1]}, 32'd1);

        // command reset in the middle of a data command
        @(negedge clk);
        cmd_word = mkw(6'd24, 2'd2, 1, 1, 1); cmd_arg = 32'h40; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (5) tk(1'b1);
        @(negedge clk);
        rst_cmd = 1'b1;
        @(negedge clk);
        rst_cmd = 1'b0;
        chk("R13 cmd inhibit cleared", {31'd0, cmd_inhibit}, 32'd0);
        chk("R13 dat inhibit kept", {31'd0, dat_inhibit}, 32'd1);
        repeat (3) tk(1'b1);
        chk("R13 line released", {30'd0, cmd_oe, cmd_out}, 32'd1);
        @(negedge clk);
        rst_dat = 1'b1;
        @(negedge clk);
        rst_dat = 1'b0;
        chk("R13 data reset", {31'd0, dat_inhibit}, 32'd0);

        for (int n = 0; n < 30; n++) begin
            logic [31:0] w;
            w = $urandom;
            run_txn(w, $urandom, int'($urandom_range(0, 4)), int'($urandom_range(0, 63)), 0, 0);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule